// File: doc/BRIEF.md
# Two-Channel Result Ready Tracker

This block keeps one "unread result" flag for each of two conversion channels and holds the latest result of each channel. A new-result strobe loads that channel's result register and raises its flag. The start of a read of that register lowers the flag. While a read of a channel's register is under way, fresh results for that channel are thrown away, so a read never sees a register that changes under it. A dropped result is not queued, because the next conversion supplies newer data.

A mode-register write pulse clears every flag. A calibration run holds all flags at zero, and its completion sets them all. The flags are packed into an 8-bit status byte. An active-low ready output combines them in one of two ways, chosen by a select bit: low when any channel has unread data, or low only when every enabled channel has unread data. The serial interface that produces the read pulses and the arithmetic that produces the results both sit outside this block.

Top module: `result_ready_tracker`

## Requirements
- R1: With no read in progress on the channel, no calibration running and no mode write, a pulse on `convDone[c]` loads `convData` slice c into `resultData` slice c (channel 0 in bits 15:0, channel 1 in bits 31:16) and sets that channel's flag. Both changes are visible after the next clock edge.
- R2: A pulse on `rdStart[c]` clears channel c's flag. If `convDone[c]` arrives in the same cycle, the read start wins: the flag clears and the result register keeps its old value.
- R3: From the `rdStart[c]` cycle through the matching `rdEnd[c]` cycle inclusive, `convDone[c]` pulses are dropped: neither the register nor the flag changes. After `rdEnd[c]`, the next pulse loads normally.
- R4: A `modeWrite` pulse clears both flags. A result strobe in the same cycle still loads its data, but its flag stays clear.
- R5: From the `calStart` cycle up to and including the `calDone` cycle, both flags read 0 and result strobes are ignored. After `calDone`, both flags read 1.
- R6: `statusByte` bit 0 carries channel 0's flag and bit 2 carries channel 1's flag. All other bits are always 0.
- R7: With `allEnMode` = 0, `readyN` is 0 when any flag is set and 1 otherwise.
- R8: With `allEnMode` = 1, `readyN` is 0 only when at least one bit of `chanEn` is set and every enabled channel's flag is set. With `chanEn` = 0 it stays 1. A change of `chanEn` or `allEnMode` takes effect in the same cycle.
- R9: After reset, both result slices hold 16'h8000, `statusByte` is 8'h00 and `readyN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convDone | input | 2 | New-result strobe per channel |
| convData | input | 32 | New result data, channel c in bits 16c+15:16c |
| rdStart | input | 2 | Pulse when a read of channel c's result begins |
| rdEnd | input | 2 | Pulse when that read completes |
| modeWrite | input | 1 | Mode-register write pulse |
| calStart | input | 1 | Calibration start pulse |
| calDone | input | 1 | Calibration complete pulse |
| chanEn | input | 2 | Channel enable bits for the all-enabled ready mode |
| allEnMode | input | 1 | Ready function select: 0 any channel, 1 all enabled channels |
| statusByte | output | 8 | Flag byte (bit 0 channel 0, bit 2 channel 1) |
| resultData | output | 32 | Held results, channel c in bits 16c+15:16c |
| readyN | output | 1 | Active-low combined ready |

## Verification
The assertions assume that every control input is a one-cycle pulse. They also assume that `calStart` and `calDone` never share a cycle, and that a read of a channel closes with `rdEnd` before the next `rdStart` on that channel. The bench drives each pulse for exactly one clock, at the falling edge, and pairs every read start with its end. Calibration start and done always fall in separate cycles. The cases where two pulses meet, read start with a new result and mode write with a new result, are driven on purpose within these limits.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int CH_COUNT    = 2;
  localparam int STATUS_W    = 8;
  localparam int FLAG_STRIDE = 2;

  // per-channel commands from control to datapath
  typedef struct packed {
    logic [CH_COUNT-1:0] load;
    logic [CH_COUNT-1:0] flagSet;
    logic [CH_COUNT-1:0] flagClr;
  } ctrl_strobe_t;
endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
  import rrt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_COUNT-1:0] convDone,
  input  logic [CH_COUNT-1:0] rdStart,
  input  logic [CH_COUNT-1:0] rdEnd,
  input  logic                modeWrite,
  input  logic                calStart,
  input  logic                calDone,
  output ctrl_strobe_t        strb
);
  logic [CH_COUNT-1:0] readingQ;
  logic                calQ;
  logic                calBusy;

  assign calBusy = calQ | calStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        calQ <= 1'b0;
    else if (calDone)  calQ <= 1'b0;
    else if (calStart) calQ <= 1'b1;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    logic busy;

    // a read opening this cycle already counts as in progress
    assign busy = readingQ[ch] | rdStart[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              readingQ[ch] <= 1'b0;
      else if (rdStart[ch])    readingQ[ch] <= 1'b1;
      else if (rdEnd[ch])      readingQ[ch] <= 1'b0;
    end

    assign strb.load[ch]    = convDone[ch] & ~busy & ~calBusy;
    assign strb.flagSet[ch] = calDone | (strb.load[ch] & ~modeWrite);
    assign strb.flagClr[ch] = ~calDone & (calBusy | modeWrite | rdStart[ch]);
  end
endmodule

// File: rtl/rrt_datapath.sv
module rrt_datapath
  import rrt_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrl_strobe_t                 strb,
  input  logic [CH_COUNT*DATA_W-1:0]   convData,
  input  logic [CH_COUNT-1:0]          chanEn,
  input  logic                         allEnMode,
  output logic [STATUS_W-1:0]          statusByte,
  output logic [CH_COUNT*DATA_W-1:0]   resultData,
  output logic                         readyN
);
  logic [CH_COUNT-1:0] flagQ;
  logic                anyPending;
  logic                allPending;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        resultData[ch*DATA_W +: DATA_W] <= RESET_VAL;
      else if (strb.load[ch])
        resultData[ch*DATA_W +: DATA_W] <= convData[ch*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flagQ[ch] <= 1'b0;
      else if (strb.flagSet[ch])  flagQ[ch] <= 1'b1;
      else if (strb.flagClr[ch])  flagQ[ch] <= 1'b0;
    end
  end

  always_comb begin
    statusByte = '0;
    for (int ch = 0; ch < CH_COUNT; ch++)
      statusByte[ch*FLAG_STRIDE] = flagQ[ch];
  end

  assign anyPending = |flagQ;
  assign allPending = (|chanEn) & (&(flagQ | ~chanEn));
  assign readyN     = allEnMode ? ~allPending : ~anyPending;
endmodule

// File: rtl/result_ready_tracker.sv
module result_ready_tracker
  import rrt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 convDone,
  input  logic [2*DATA_W-1:0]        convData,
  input  logic [1:0]                 rdStart,
  input  logic [1:0]                 rdEnd,
  input  logic                       modeWrite,
  input  logic                       calStart,
  input  logic                       calDone,
  input  logic [1:0]                 chanEn,
  input  logic                       allEnMode,
  output logic [7:0]                 statusByte,
  output logic [2*DATA_W-1:0]        resultData,
  output logic                       readyN
);
  localparam logic [DATA_W-1:0] RESULT_RST = {1'b1, {(DATA_W-1){1'b0}}};

  ctrl_strobe_t strb;

  rrt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .convDone  (convDone),
    .rdStart   (rdStart),
    .rdEnd     (rdEnd),
    .modeWrite (modeWrite),
    .calStart  (calStart),
    .calDone   (calDone),
    .strb      (strb)
  );

  rrt_datapath #(.DATA_W(DATA_W), .RESET_VAL(RESULT_RST)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .convData   (convData),
    .chanEn     (chanEn),
    .allEnMode  (allEnMode),
    .statusByte (statusByte),
    .resultData (resultData),
    .readyN     (readyN)
  );
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          rdStart,
  input logic                modeWrite,
  input logic                calStart,
  input logic                calDone,
  input logic                allEnMode,
  input logic [7:0]          statusByte,
  input logic [2*DATA_W-1:0] resultData,
  input logic                readyN
);
  logic calOpen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        calOpen <= 1'b0;
    else if (calDone)  calOpen <= 1'b0;
    else if (calStart) calOpen <= 1'b1;
  end

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rdStart[0] && !calDone |=> !statusByte[0]);

  a_r2_read_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    rdStart[1] |=> $stable(resultData[2*DATA_W-1:DATA_W]));

  a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    modeWrite && !calDone |=> statusByte == 8'h00);

  a_r5_cal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    calOpen |-> statusByte == 8'h00);

  a_r5_cal_done: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |=> statusByte == 8'h05);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (statusByte & 8'hFA) == 8'h00);

  a_r7_any_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !allEnMode |-> readyN == (statusByte == 8'h00));
endmodule

bind result_ready_tracker rrt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdStart    (rdStart),
  .modeWrite  (modeWrite),
  .calStart   (calStart),
  .calDone    (calDone),
  .allEnMode  (allEnMode),
  .statusByte (statusByte),
  .resultData (resultData),
  .readyN     (readyN)
);

// File: tb/result_ready_tracker_test.sv
module result_ready_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    convDone = '0;
  logic [2*DW-1:0] convData = '0;
  logic [1:0]    rdStart = '0;
  logic [1:0]    rdEnd = '0;
  logic          modeWrite = 1'b0;
  logic          calStart = 1'b0;
  logic          calDone = 1'b0;
  logic [1:0]    chanEn = '0;
  logic          allEnMode = 1'b0;
  logic [7:0]    statusByte;
  logic [2*DW-1:0] resultData;
  logic          readyN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_ready_tracker #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .convDone(convDone), .convData(convData),
    .rdStart(rdStart), .rdEnd(rdEnd), .modeWrite(modeWrite),
    .calStart(calStart), .calDone(calDone), .chanEn(chanEn),
    .allEnMode(allEnMode), .statusByte(statusByte),
    .resultData(resultData), .readyN(readyN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // clear all pulses at the next falling edge, where the posedge result is visible
  task automatic step();
    @(negedge clk);
    convDone = '0; rdStart = '0; rdEnd = '0;
    modeWrite = 1'b0; calStart = 1'b0; calDone = 1'b0;
  endtask

  task automatic test_reset();
    chk("R9 status", {24'h0, statusByte}, 32'h00);
    chk("R9 results", resultData, 32'h8000_8000);
    chk("R9 readyN", {31'h0, readyN}, 32'h1);
  endtask

  task automatic test_load();
    convDone = 2'b01; convData = 32'h0000_1234;
    step();
    chk("R1 ch0 flag", {24'h0, statusByte}, 32'h01);
    chk("R1 ch0 data", resultData, 32'h8000_1234);
    chk("R7 any ready", {31'h0, readyN}, 32'h0);
    convDone = 2'b10; convData = 32'hABCD_0000;
    step();
    chk("R6 layout", {24'h0, statusByte}, 32'h05);
    chk("R1 ch1 data", resultData, 32'hABCD_1234);
  endtask

  task automatic test_read_block();
    rdStart = 2'b01;
    step();
    chk("R2 read clears", {24'h0, statusByte}, 32'h04);
    convDone = 2'b01; convData = 32'h0000_5555;
    step();
    chk("R3 blocked flag", {24'h0, statusByte}, 32'h04);
    chk("R3 blocked data", resultData, 32'hABCD_1234);
    rdEnd = 2'b01; convDone = 2'b01; convData = 32'h0000_5A5A;
    step();
    chk("R3 end cycle blocked", resultData, 32'hABCD_1234);
    convDone = 2'b01; convData = 32'h0000_6666;
    step();
    chk("R3 after end flag", {24'h0, statusByte}, 32'h05);
    chk("R3 after end data", resultData, 32'hABCD_6666);
  endtask

  task automatic test_same_cycle();
    rdStart = 2'b10; convDone = 2'b10; convData = 32'h7777_0000;
    step();
    chk("R2 start wins flag", {24'h0, statusByte}, 32'h01);
    chk("R2 start wins data", resultData, 32'hABCD_6666);
    rdEnd = 2'b10;
    step();
  endtask

  task automatic test_all_mode();
    allEnMode = 1'b1; chanEn = 2'b11;
    #1 chk("R8 one missing", {31'h0, readyN}, 32'h1);
    convDone = 2'b10; convData = 32'h9999_0000;
    step();
    chk("R8 all set", {31'h0, readyN}, 32'h0);
    chanEn = 2'b00;
    #1 chk("R8 none enabled", {31'h0, readyN}, 32'h1);
    rdStart = 2'b10; chanEn = 2'b01;
    step();
    chk("R8 ch0 only enabled", {31'h0, readyN}, 32'h0);
    rdEnd = 2'b10;
    step();
  endtask

  task automatic test_mode_write();
    modeWrite = 1'b1; convDone = 2'b01; convData = 32'h0000_4242;
    step();
    chk("R4 flags cleared", {24'h0, statusByte}, 32'h00);
    chk("R4 data loads", resultData, 32'h9999_4242);
    chk("R8 empty ready", {31'h0, readyN}, 32'h1);
  endtask

  task automatic test_calibration();
    convDone = 2'b01; convData = 32'h0000_0F0F;
    step();
    chk("R1 reload", {24'h0, statusByte}, 32'h01);
    calStart = 1'b1;
    step();
    chk("R5 start clears", {24'h0, statusByte}, 32'h00);
    convDone = 2'b11; convData = 32'h1111_1111;
    step();
    chk("R5 quiet flags", {24'h0, statusByte}, 32'h00);
    chk("R5 results ignored", resultData, 32'h9999_0F0F);
    calDone = 1'b1;
    step();
    chk("R5 done sets", {24'h0, statusByte}, 32'h05);
    chk("R8 after cal", {31'h0, readyN}, 32'h0);
    allEnMode = 1'b0;
    #1 chk("R7 any after cal", {31'h0, readyN}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    test_reset();
    test_load();
    test_read_block();
    test_same_cycle();
    test_all_mode();
    test_mode_write();
    test_calibration();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule